// File: doc/BRIEF.md
# Programmable Crosspoint Output Cell Array

This block is a small programmable routing fabric. A row of input pins is divided into four equal groups, and each output cell can route one pin from each group to the four inputs of its own 4:1 multiplexer. Two select controls steer that multiplexer while the block runs. The chosen value can pass straight through, be captured in a flip-flop on an edge of a routed clock, or be held in a transparent latch. A routed output-enable then gates the result. Every control (output enable, storage clock, clock enable and both selects) is taken from any input pin, and each one has its own per-cell inversion bit.

A cell can also ignore routing and drive a constant high or low, in the way a jumper or DIP switch would. An expander bit makes a cell select among the four 4:1 results of its aligned quad of neighbours, which gives a 16:1 choice at one output. Software-free configuration arrives through a one-word write port, one word per cell. Reset clears every word, and this leaves every output undriven. A true tri-state pin is modelled as a data bit plus an enable flag. The routed storage clock is a pin value that is sampled on the system clock, so a rising edge on it is detected when the value changes from 0 to 1 between two system clock cycles.

Top module: `xpt_fabric`

## Requirements
- R1: When `cfg_we` is 1 and reset is low, `cfg_wdata` is stored for cell `cfg_addr` at the clock edge and controls that cell from the next cycle. The word layout is: [36:34] mode, [33] expand, [32] invert OE, [31] invert clock, [30] invert clock enable, [29] invert select 1, [28] invert select 0, [27:24] OE pin, [23:20] clock pin, [19:16] clock-enable pin, [15:12] select-1 pin, [11:8] select-0 pin, [7:6] group D pin, [5:4] group C pin, [3:2] group B pin, [1:0] group A pin.
- R2: Synchronous reset clears all configuration words (mode 0) and storage, so every cell shows `out_en`=0 and `out_data`=0.
- R3: Group g (A=0 … D=3) holds pins 4g…4g+3. The cell's 4:1 multiplexer takes the pin that the field for that group picks, and select code {sel1, sel0} chooses group A, B, C or D for codes 0 to 3.
- R4: Each effective control equals the value of its routed pin XOR its inversion bit. This holds for the OE, clock, clock-enable, select-1 and select-0 controls.
- R5: In modes 1–3, when the effective OE is 0 the cell gives `out_en`=0 and `out_data`=0. When it is 1, `out_en`=1.
- R6: Mode 1 (direct) drives the selected value combinationally in the same cycle.
- R7: Mode 2 (register) captures the selected value at a system clock edge when the effective clock was 0 in the previous cycle, is 1 now, and the effective clock enable is 1. The output shows the captured value.
- R8: When the effective clock enable is 0, the stored value does not change in either storage mode.
- R9: Mode 3 (latch) passes the selected value through while the effective clock and the effective clock enable are both 1. Otherwise it shows the last value that passed.
- R10: Mode 4 drives a constant 0 and mode 5 drives a constant 1, both with `out_en`=1, whatever the routing and the OE.
- R11: With the expand bit set, the cell in quad k (cells 4k…4k+3) uses the 4:1 result of neighbour 4k+{sel1,sel0} in place of its own result. That neighbour's result is formed with the neighbour's own routing and selects.
- R12: Mode 0 and any unused mode code keep `out_en`=0 and `out_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Cell index to write |
| cfg_wdata | input | 37 | Configuration word |
| pin_in | input | 16 | Input pins, four groups of four |
| out_data | output | 8 | Per-cell output value (0 when not driven) |
| out_en | output | 8 | Per-cell drive enable |

## Verification
A wrong configuration word or a wrong select decode shows up at once in the same cycle as a wrong `out_data` bit. This is because direct mode is combinational, and the bench compares every cell against its reference model on every cycle. A storage fault, such as a missed edge, a wrong enable polarity or a leaking latch, stays hidden until the next cycle in which that cell is enabled and its stored value differs from the fresh data. Random pin patterns make that happen within a few cycles. A reset that fails to clear configuration shows up as a cell that is still driving in the first cycle after reset.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

    parameter int GROUP_PINS = 4;
    localparam int NUM_GROUPS = 4;
    localparam int XPT_PINS = NUM_GROUPS * GROUP_PINS;
    localparam int GSEL_W = $clog2(GROUP_PINS);
    localparam int PSEL_W = $clog2(XPT_PINS);

    typedef enum logic [2:0] {
        MODE_OFF      = 3'd0,
        MODE_DIRECT   = 3'd1,
        MODE_REG      = 3'd2,
        MODE_LATCH    = 3'd3,
        MODE_FORCE_LO = 3'd4,
        MODE_FORCE_HI = 3'd5
    } xpt_mode_e;

    typedef struct packed {
        xpt_mode_e                             mode;
        logic                                  expand;
        logic                                  pol_oe;
        logic                                  pol_clk;
        logic                                  pol_ce;
        logic                                  pol_s1;
        logic                                  pol_s0;
        logic [PSEL_W-1:0]                     oe_src;
        logic [PSEL_W-1:0]                     clk_src;
        logic [PSEL_W-1:0]                     ce_src;
        logic [PSEL_W-1:0]                     s1_src;
        logic [PSEL_W-1:0]                     s0_src;
        logic [NUM_GROUPS-1:0][GSEL_W-1:0]     dsrc;
    } xpt_cfg_t;

    localparam int CFG_W = $bits(xpt_cfg_t);

    typedef struct packed {
        logic       oe;
        logic       clk;
        logic       ce;
        logic [1:0] sel;
    } xpt_ctl_t;

    function automatic logic routed_ctl(input logic [XPT_PINS-1:0] pins,
                                        input logic [PSEL_W-1:0] src,
                                        input logic inv);
        return pins[src] ^ inv;
    endfunction

endpackage

// File: rtl/xpt_cfg_store.sv
module xpt_cfg_store
    import xpt_pkg::*;
#(
    parameter int NUM_CELLS = 8,
    localparam int CAW = $clog2(NUM_CELLS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [CAW-1:0]            addr,
    input  xpt_cfg_t                  wdata,
    output xpt_cfg_t [NUM_CELLS-1:0]  cfg_q
);

    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i] <= '0;
            end else if (we && addr == CAW'(i)) begin
                cfg_q[i] <= wdata;
            end
        end

        assert_cfg_load_R1: assert property (@(posedge clk) disable iff (rst)
            (we && addr == CAW'(i)) |=> (cfg_q[i] == $past(wdata)));

        assert_reset_off_R2: assert property (@(posedge clk)
            rst |=> (cfg_q[i].mode == MODE_OFF));
    end

endmodule

// File: rtl/xpt_cell_sel.sv
module xpt_cell_sel
    import xpt_pkg::*;
(
    input  logic [XPT_PINS-1:0] pins,
    input  xpt_cfg_t            cfg,
    output xpt_ctl_t            ctl,
    output logic                raw
);

    logic [NUM_GROUPS-1:0][GROUP_PINS-1:0] grp;
    logic [NUM_GROUPS-1:0]                 cand;

    assign grp = pins;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_cand
        assign cand[g] = grp[g][cfg.dsrc[g]];
    end

    always_comb begin
        ctl.oe     = routed_ctl(pins, cfg.oe_src,  cfg.pol_oe);
        ctl.clk    = routed_ctl(pins, cfg.clk_src, cfg.pol_clk);
        ctl.ce     = routed_ctl(pins, cfg.ce_src,  cfg.pol_ce);
        ctl.sel[1] = routed_ctl(pins, cfg.s1_src,  cfg.pol_s1);
        ctl.sel[0] = routed_ctl(pins, cfg.s0_src,  cfg.pol_s0);
    end

    assign raw = cand[ctl.sel];

endmodule

// File: rtl/xpt_cell_store.sv
module xpt_cell_store
    import xpt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  xpt_mode_e mode,
    input  xpt_ctl_t  ctl,
    input  logic      din,
    output logic      out_data,
    output logic      out_en
);

    logic prev_clk;
    logic held;
    logic upd;
    logic open_gate;

    assign open_gate = ctl.clk & ctl.ce;

    always_comb begin
        case (mode)
            MODE_REG:   upd = ctl.clk & ~prev_clk & ctl.ce;
            MODE_LATCH: upd = open_gate;
            default:    upd = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_clk <= 1'b0;
            held     <= 1'b0;
        end else begin
            prev_clk <= ctl.clk;
            if (upd) begin
                held <= din;
            end
        end
    end

    always_comb begin
        out_en   = 1'b0;
        out_data = 1'b0;
        case (mode)
            MODE_DIRECT: begin
                out_en   = ctl.oe;
                out_data = ctl.oe & din;
            end
            MODE_REG: begin
                out_en   = ctl.oe;
                out_data = ctl.oe & held;
            end
            MODE_LATCH: begin
                out_en   = ctl.oe;
                out_data = ctl.oe & (open_gate ? din : held);
            end
            MODE_FORCE_LO: begin
                out_en   = 1'b1;
                out_data = 1'b0;
            end
            MODE_FORCE_HI: begin
                out_en   = 1'b1;
                out_data = 1'b1;
            end
            default: begin
                out_en   = 1'b0;
                out_data = 1'b0;
            end
        endcase
    end

    assert_oe_gate_R5: assert property (@(posedge clk) disable iff (rst)
        ((mode == MODE_DIRECT || mode == MODE_REG || mode == MODE_LATCH) && !ctl.oe)
            |-> (!out_en && !out_data));

    assert_reg_capture_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_REG && ctl.clk && !prev_clk && ctl.ce) |=> (held == $past(din)));

    assert_ce_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !ctl.ce |=> $stable(held));

    assert_latch_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LATCH && !ctl.clk) |=> $stable(held));

    assert_force_hi_R10: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FORCE_HI) |-> (out_en && out_data));

    assert_off_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OFF) |-> (!out_en && !out_data));

endmodule

// File: rtl/xpt_fabric.sv
module xpt_fabric
    import xpt_pkg::*;
#(
    parameter int NUM_CELLS = 8,
    localparam int CAW = $clog2(NUM_CELLS),
    localparam int NUM_QUADS = NUM_CELLS / 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [CAW-1:0]        cfg_addr,
    input  logic [CFG_W-1:0]      cfg_wdata,
    input  logic [XPT_PINS-1:0]   pin_in,
    output logic [NUM_CELLS-1:0]  out_data,
    output logic [NUM_CELLS-1:0]  out_en
);

    xpt_cfg_t [NUM_CELLS-1:0] cfg_q;
    xpt_ctl_t [NUM_CELLS-1:0] ctl;
    logic     [NUM_CELLS-1:0] raw;
    logic     [NUM_CELLS-1:0] chosen;

    xpt_cfg_store #(.NUM_CELLS(NUM_CELLS)) cfg_i (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (xpt_cfg_t'(cfg_wdata)),
        .cfg_q (cfg_q)
    );

    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
        localparam int BASE = (i / 4) * 4;
        logic [3:0] quad;

        xpt_cell_sel sel_i (
            .pins (pin_in),
            .cfg  (cfg_q[i]),
            .ctl  (ctl[i]),
            .raw  (raw[i])
        );

        assign quad      = raw[BASE +: 4];
        assign chosen[i] = cfg_q[i].expand ? quad[ctl[i].sel] : raw[i];

        xpt_cell_store store_i (
            .clk      (clk),
            .rst      (rst),
            .mode     (cfg_q[i].mode),
            .ctl      (ctl[i]),
            .din      (chosen[i]),
            .out_data (out_data[i]),
            .out_en   (out_en[i])
        );
    end

    initial begin
        assert_quad_multiple_R11: assert (NUM_CELLS % 4 == 0 && NUM_QUADS > 0);
    end

endmodule

// File: tb/xpt_fabric_tb.sv
module xpt_fabric_tb_top;
    import xpt_pkg::*;

    localparam int NC = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_we = 1'b0;
    logic [2:0]      cfg_addr = '0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic [15:0]     pin_in = '0;
    logic [NC-1:0]   out_data;
    logic [NC-1:0]   out_en;

    int    checks = 0;
    int    fails = 0;
    bit    cmp_en = 0;
    bit    done = 0;
    string phase = "init";
    logic [31:0] lfsr = 32'h1ACE_B00C;

    xpt_cfg_t   mcfg [NC];
    logic       mq   [NC];
    logic       mprev[NC];

    always #5ns clk = ~clk;

    xpt_fabric #(.NUM_CELLS(NC)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pin_in(pin_in),
        .out_data(out_data), .out_en(out_en)
    );

    function automatic logic [15:0] next_rand();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        lfsr = lfsr ^ (lfsr << 7);
        return lfsr[23:8];
    endfunction

    function automatic xpt_cfg_t mk(xpt_mode_e m, bit ex, logic [4:0] pols,
                                    int oe, int ck, int ce, int s1, int s0,
                                    int a, int b, int c, int d);
        xpt_cfg_t w = '0;
        w.mode = m; w.expand = ex;
        {w.pol_oe, w.pol_clk, w.pol_ce, w.pol_s1, w.pol_s0} = pols;
        w.oe_src = 4'(oe); w.clk_src = 4'(ck); w.ce_src = 4'(ce);
        w.s1_src = 4'(s1); w.s0_src = 4'(s0);
        w.dsrc[0] = 2'(a); w.dsrc[1] = 2'(b); w.dsrc[2] = 2'(c); w.dsrc[3] = 2'(d);
        return w;
    endfunction

    function automatic int sel_of(int j, logic [15:0] p);
        int hi = (p[mcfg[j].s1_src] ^ mcfg[j].pol_s1) ? 2 : 0;
        int lo = (p[mcfg[j].s0_src] ^ mcfg[j].pol_s0) ? 1 : 0;
        return hi + lo;
    endfunction

    function automatic logic raw_of(int j, logic [15:0] p);
        int g = sel_of(j, p);
        return p[g * 4 + int'(mcfg[j].dsrc[g])];
    endfunction

    function automatic logic value_of(int i, logic [15:0] p);
        if (mcfg[i].expand) return raw_of((i / 4) * 4 + sel_of(i, p), p);
        return raw_of(i, p);
    endfunction

    function automatic logic [1:0] model_out(int i, logic [15:0] p);
        logic v  = value_of(i, p);
        logic oe = p[mcfg[i].oe_src] ^ mcfg[i].pol_oe;
        logic ck = p[mcfg[i].clk_src] ^ mcfg[i].pol_clk;
        logic ce = p[mcfg[i].ce_src] ^ mcfg[i].pol_ce;
        case (mcfg[i].mode)
            MODE_DIRECT:   return oe ? {1'b1, v} : 2'b00;
            MODE_REG:      return oe ? {1'b1, mq[i]} : 2'b00;
            MODE_LATCH:    return oe ? {1'b1, (ck && ce) ? v : mq[i]} : 2'b00;
            MODE_FORCE_LO: return 2'b10;
            MODE_FORCE_HI: return 2'b11;
            default:       return 2'b00;
        endcase
    endfunction

    task automatic step(bit r, bit we, int addr, xpt_cfg_t w);
        logic [15:0] p = next_rand();
        @(negedge clk);
        rst = r; cfg_we = we; cfg_addr = 3'(addr); cfg_wdata = w; pin_in = p;
        #1ns;
        if (cmp_en) begin
            for (int i = 0; i < NC; i++) begin
                logic [1:0] e = model_out(i, p);
                checks++;
                if ({out_en[i], out_data[i]} !== e) begin
                    fails++;
                    $display("FAIL %s cell %0d: got en/data %b%b expected %b",
                             phase, i, out_en[i], out_data[i], e);
                end
            end
        end
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < NC; i++) begin
                mcfg[i] = '0; mq[i] = 1'b0; mprev[i] = 1'b0;
            end
        end else begin
            for (int i = 0; i < NC; i++) begin
                logic v  = value_of(i, p);
                logic ck = p[mcfg[i].clk_src] ^ mcfg[i].pol_clk;
                logic ce = p[mcfg[i].ce_src] ^ mcfg[i].pol_ce;
                if (mcfg[i].mode == MODE_REG && ck && !mprev[i] && ce) mq[i] = v;
                if (mcfg[i].mode == MODE_LATCH && ck && ce) mq[i] = v;
                mprev[i] = ck;
            end
            if (we) mcfg[addr] = w;
        end
    endtask

    task automatic wr(int addr, xpt_cfg_t w);
        step(0, 1, addr, w);
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, '0);
    endtask

    initial begin
        #2_000_000ns;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NC; i++) begin
            mcfg[i] = '0; mq[i] = 1'b0; mprev[i] = 1'b0;
        end
        step(1, 0, 0, '0);
        step(1, 0, 0, '0);
        cmp_en = 1;

        phase = "R2 R12 reset state";
        run(4);

        phase = "R1 R3 R5 R6 direct routing";
        wr(0, mk(MODE_DIRECT, 0, 5'b00000, 15, 0, 0, 6, 1, 1, 2, 3, 0));
        wr(1, mk(MODE_DIRECT, 0, 5'b00000, 12, 0, 0, 0, 15, 0, 1, 2, 3));
        wr(2, mk(MODE_DIRECT, 0, 5'b00000, 3, 0, 0, 9, 4, 3, 3, 0, 1));
        run(64);

        phase = "R1 R4 polarity inversion";
        wr(3, mk(MODE_DIRECT, 0, 5'b10000, 7, 0, 0, 2, 11, 2, 0, 1, 3));
        wr(4, mk(MODE_DIRECT, 0, 5'b00010, 14, 0, 0, 5, 8, 0, 3, 2, 1));
        wr(5, mk(MODE_DIRECT, 0, 5'b00001, 1, 0, 0, 13, 10, 1, 1, 1, 1));
        wr(6, mk(MODE_REG,    0, 5'b01000, 2, 9, 6, 3, 4, 0, 2, 0, 2));
        wr(7, mk(MODE_REG,    0, 5'b00100, 0, 10, 11, 7, 12, 3, 2, 1, 0));
        run(64);

        phase = "R7 R8 register capture and enable hold";
        wr(0, mk(MODE_REG, 0, 5'b00000, 15, 14, 13, 6, 1, 1, 2, 3, 0));
        wr(1, mk(MODE_REG, 0, 5'b00000, 4, 3, 8, 0, 15, 0, 1, 2, 3));
        run(64);

        phase = "R8 R9 latch transparency";
        wr(2, mk(MODE_LATCH, 0, 5'b00000, 3, 5, 9, 9, 4, 3, 3, 0, 1));
        wr(5, mk(MODE_LATCH, 0, 5'b01100, 1, 14, 2, 13, 10, 1, 0, 2, 3));
        run(64);

        phase = "R10 R12 forced levels and off";
        wr(0, mk(MODE_FORCE_HI, 0, 5'b11111, 15, 14, 13, 6, 1, 1, 2, 3, 0));
        wr(1, mk(MODE_FORCE_LO, 0, 5'b00000, 4, 3, 8, 0, 15, 0, 1, 2, 3));
        wr(3, mk(MODE_OFF,      0, 5'b00000, 7, 0, 0, 2, 11, 2, 0, 1, 3));
        wr(7, mk(xpt_mode_e'(3'd7), 0, 5'b00000, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        run(48);

        phase = "R11 expander 16:1";
        wr(4, mk(MODE_DIRECT, 0, 5'b00000, 14, 0, 0, 5, 8, 0, 3, 2, 1));
        wr(5, mk(MODE_DIRECT, 1, 5'b00000, 9, 0, 0, 15, 2, 1, 0, 2, 3));
        wr(6, mk(MODE_REG,    1, 5'b00001, 2, 11, 0, 3, 4, 0, 2, 0, 2));
        wr(7, mk(MODE_DIRECT, 0, 5'b00000, 13, 0, 0, 7, 12, 3, 2, 1, 0));
        wr(1, mk(MODE_LATCH,  1, 5'b00000, 4, 6, 10, 0, 15, 2, 1, 0, 3));
        run(96);

        phase = "R2 reset clears configuration";
        step(1, 0, 0, '0);
        step(1, 1, 2, mk(MODE_FORCE_HI, 0, 5'b0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        run(6);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule